// File: doc/BRIEF.md
# Bit Manipulation and Byte Align Unit

This unit is a 64-bit execution slice for a processor datapath. Each cycle it takes an operation code, two source operands A and B, and the old value of the destination register D, which the variable align uses as a third source. It returns one 64-bit result. Its operations fall into three groups. The counting group gives leading zeros, trailing zeros and set bits. The permuting group reverses the bit order or the byte order of A. The align group funnel-shifts a 128-bit register pair right by whole bytes and keeps the low word.

The variable align takes its byte count from the three low bits of B and uses D as the lower half. The three fixed aligns place B in the lower half and shift by 2, 4 or 6 bytes. An operation code outside the defined set gives a zero result and raises an illegal flag. A parameter selects an output register. With the default setting the result, the flag and the valid bit appear one clock after their inputs.

Top module: `bmu_top`

## Requirements
- R1: Op code 0 returns the number of leading zero bits of A, counted from bit 63 downward, zero-extended to 64 bits. An all-zero A gives 64.
- R2: Op code 1 returns the number of trailing zero bits of A, counted from bit 0 upward, zero-extended to 64 bits. An all-zero A gives 64.
- R3: Op code 2 returns the number of bits of A that are set to one.
- R4: Op code 3 returns A with bit i moved to bit 63-i.
- R5: Op code 4 returns A with byte k (bits 8k+7..8k) moved to byte 7-k.
- R6: Op code 5 returns the low 64 bits of the 128-bit value {A, D} shifted right by 8*B[2:0] bits. When B[2:0] is 0 the result equals D exactly.
- R7: For op code 5, bits 63..3 of B have no effect on the result.
- R8: Op codes 6, 7 and 8 return the low 64 bits of {A, B} shifted right by 16, 32 and 48 bits respectively.
- R9: Op codes 9 to 15 give a zero result with illegal set to 1. Op codes 0 to 8 give illegal 0.
- R10: With the output register enabled (the default), result and illegal reflect the inputs of the previous clock edge, and valid_out equals valid_in of the previous edge. A synchronous active-high rst clears valid_out, result and illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Marks the current inputs as an issued operation |
| op | input | 4 | Operation code |
| src_a | input | 64 | Source operand A |
| src_b | input | 64 | Source operand B (align amount or lower half) |
| src_d | input | 64 | Old destination value, lower half of the variable align |
| valid_out | output | 1 | Valid bit aligned with result |
| result | output | 64 | Operation result |
| illegal | output | 1 | High when the operation code is undefined |

## Verification
The counting operations are tried with an all-zero A, an all-ones A, and a single set bit walked over all 64 positions. These patterns separate an off-by-one or a wrong direction in the counts and expose a wrong bit or byte mapping in the reversals. The variable align is run for every value of B[2:0], each time with random upper bits in B. Each result is compared with the same shift using a clean B, which confirms that the zero shift returns D untouched and that the upper bits of B are ignored. Seeded random operands over all sixteen codes cover the mixed cases and the illegal codes. Toggling valid_in confirms the one-cycle alignment of valid_out.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_CLZ    = 4'd0,
      OP_CTZ    = 4'd1,
      OP_POPC   = 4'd2,
      OP_BITREV = 4'd3,
      OP_BYTREV = 4'd4,
      OP_ALIGN  = 4'd5,
      OP_ALIGN2 = 4'd6,
      OP_ALIGN4 = 4'd7,
      OP_ALIGN6 = 4'd8
   } bmu_op_e;

   // fixed aligns shift by FIX_STEP_BYTES * (k+1) bytes, k = 0..FIX_COUNT-1
   localparam int FIX_COUNT      = 3;
   localparam int FIX_STEP_BYTES = 2;
endpackage

// File: rtl/bmu_count.sv
module bmu_count #(
   parameter int DATA_W = 64,
   localparam int CNT_W = $clog2(DATA_W) + 1
) (
   input  logic [DATA_W-1:0] a_i,
   output logic [CNT_W-1:0]  clz_o,
   output logic [CNT_W-1:0]  ctz_o,
   output logic [CNT_W-1:0]  pop_o
);
   logic hit_hi, hit_lo;

   always_comb begin
      clz_o  = '0;
      hit_hi = 1'b0;
      for (int i = DATA_W-1; i >= 0; i--) begin
         if (!hit_hi) begin
            if (a_i[i]) hit_hi = 1'b1;
            else        clz_o  = clz_o + CNT_W'(1);
         end
      end
   end

   always_comb begin
      ctz_o  = '0;
      hit_lo = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (!hit_lo) begin
            if (a_i[i]) hit_lo = 1'b1;
            else        ctz_o  = ctz_o + CNT_W'(1);
         end
      end
   end

   always_comb begin
      pop_o = '0;
      for (int i = 0; i < DATA_W; i++)
         pop_o = pop_o + CNT_W'(a_i[i]);
   end

   // R1 R2: an empty word must count full width in both directions
   always_comb begin
      if (!$isunknown(a_i) && a_i == '0)
         p_empty_full_r1: assert (clz_o == CNT_W'(DATA_W) && ctz_o == CNT_W'(DATA_W));
   end

   // R3: the zero runs at both ends and the set bits never exceed the width
   always_comb begin
      if (!$isunknown(a_i) && a_i != '0)
         p_count_sum_r3: assert ((32'(clz_o) + 32'(ctz_o) + 32'(pop_o)) <= DATA_W && pop_o != '0);
   end
endmodule

// File: rtl/bmu_permute.sv
module bmu_permute #(
   parameter int DATA_W = 64,
   localparam int BYTES = DATA_W / 8
) (
   input  logic [DATA_W-1:0] a_i,
   output logic [DATA_W-1:0] bitrev_o,
   output logic [DATA_W-1:0] byterev_o
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign bitrev_o[i] = a_i[DATA_W-1-i];
   end

   for (genvar k = 0; k < BYTES; k++) begin : g_byte
      assign byterev_o[8*k +: 8] = a_i[8*(BYTES-1-k) +: 8];
   end
endmodule

// File: rtl/bmu_align.sv
module bmu_align
   import bmu_pkg::*;
#(
   parameter int DATA_W = 64,
   localparam int BYTES = DATA_W / 8,
   localparam int SEL_W = $clog2(BYTES)
) (
   input  logic [DATA_W-1:0] hi_i,
   input  logic [DATA_W-1:0] lo_var_i,
   input  logic [DATA_W-1:0] lo_fix_i,
   input  logic [SEL_W-1:0]  sel_i,
   output logic [DATA_W-1:0] var_o,
   output logic [DATA_W-1:0] fix_o [FIX_COUNT]
);
   logic [2*DATA_W-1:0] pair_var;
   logic [2*DATA_W-1:0] pair_fix;
   logic [SEL_W+2:0]    bit_off;

   assign pair_var = {hi_i, lo_var_i};
   assign pair_fix = {hi_i, lo_fix_i};
   assign bit_off  = {sel_i, 3'b000};

   // indexed window never exceeds the pair, so a zero offset is just the low half
   assign var_o = pair_var[bit_off +: DATA_W];

   for (genvar k = 0; k < FIX_COUNT; k++) begin : g_fix
      localparam int SH = 8 * FIX_STEP_BYTES * (k + 1);
      assign fix_o[k] = pair_fix[SH +: DATA_W];
   end

   // R6: zero byte offset passes the old destination through unchanged
   always_comb begin
      if (!$isunknown(sel_i) && !$isunknown(lo_var_i) && sel_i == '0)
         p_zero_shift_keeps_d_r6: assert (var_o == lo_var_i);
   end
endmodule

// File: rtl/bmu_top.sv
module bmu_top
   import bmu_pkg::*;
#(
   parameter int DATA_W  = 64,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid_in,
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [DATA_W-1:0] src_d,
   output logic              valid_out,
   output logic [DATA_W-1:0] result,
   output logic              illegal
);
   localparam int CNT_W = $clog2(DATA_W) + 1;
   localparam int BYTES = DATA_W / 8;
   localparam int SEL_W = $clog2(BYTES);

   if (DATA_W % 8 != 0 || BYTES <= FIX_COUNT * FIX_STEP_BYTES) begin : g_bad_width
      $error("bmu_top: DATA_W must be a byte multiple wide enough for the fixed aligns");
   end

   logic [CNT_W-1:0]  clz_w, ctz_w, pop_w;
   logic [DATA_W-1:0] bitrev_w, byterev_w, var_w;
   logic [DATA_W-1:0] fix_w [FIX_COUNT];
   logic [DATA_W-1:0] res_c;
   logic              ill_c;

   bmu_count #(.DATA_W(DATA_W)) u_count (
      .a_i(src_a), .clz_o(clz_w), .ctz_o(ctz_w), .pop_o(pop_w)
   );

   bmu_permute #(.DATA_W(DATA_W)) u_perm (
      .a_i(src_a), .bitrev_o(bitrev_w), .byterev_o(byterev_w)
   );

   bmu_align #(.DATA_W(DATA_W)) u_align (
      .hi_i(src_a), .lo_var_i(src_d), .lo_fix_i(src_b),
      .sel_i(src_b[SEL_W-1:0]), .var_o(var_w), .fix_o(fix_w)
   );

   always_comb begin
      ill_c = 1'b0;
      case (op)
         OP_CLZ:    res_c = DATA_W'(clz_w);
         OP_CTZ:    res_c = DATA_W'(ctz_w);
         OP_POPC:   res_c = DATA_W'(pop_w);
         OP_BITREV: res_c = bitrev_w;
         OP_BYTREV: res_c = byterev_w;
         OP_ALIGN:  res_c = var_w;
         OP_ALIGN2: res_c = fix_w[0];
         OP_ALIGN4: res_c = fix_w[1];
         OP_ALIGN6: res_c = fix_w[2];
         default: begin
            res_c = '0;
            ill_c = 1'b1;
         end
      endcase
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            valid_out <= 1'b0;
            result    <= '0;
            illegal   <= 1'b0;
         end else begin
            valid_out <= valid_in;
            result    <= res_c;
            illegal   <= ill_c;
         end
      end

      // R10: valid bit tracks the issue one cycle later
      p_valid_follow_r10: assert property (@(posedge clk) disable iff (rst)
         valid_in |=> valid_out);
      p_valid_drop_r10: assert property (@(posedge clk) disable iff (rst)
         !valid_in |=> !valid_out);
   end else begin : g_comb
      assign valid_out = valid_in;
      assign result    = res_c;
      assign illegal   = ill_c;
   end

   // R9: a flagged operation never leaks a value
   p_illegal_zero_r9: assert property (@(posedge clk) disable iff (rst)
      illegal |-> result == '0);
endmodule

// File: tb/bmu_top_tb.sv
module bmu_top_tb;
   localparam int W = 64;

   logic         clk = 1'b0;
   logic         rst;
   logic         valid_in;
   logic [3:0]   op;
   logic [W-1:0] src_a, src_b, src_d;
   logic         valid_out;
   logic [W-1:0] result;
   logic         illegal;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   bmu_top u_dut (
      .clk(clk), .rst(rst), .valid_in(valid_in), .op(op),
      .src_a(src_a), .src_b(src_b), .src_d(src_d),
      .valid_out(valid_out), .result(result), .illegal(illegal)
   );

   function automatic logic [W-1:0] ref_model(input logic [3:0] c,
         input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] d);
      logic [W-1:0] r;
      int n, sh;
      r = '0;
      case (c)
         4'd0: begin n = 0; while (n < W && a[W-1-n] == 1'b0) n++; r = W'(n); end
         4'd1: begin n = 0; while (n < W && a[n] == 1'b0) n++; r = W'(n); end
         4'd2: begin n = 0; for (int i = 0; i < W; i++) if (a[i]) n++; r = W'(n); end
         4'd3: for (int i = 0; i < W; i++) r[W-1-i] = a[i];
         4'd4: for (int i = 0; i < W; i++) r[(7 - i/8)*8 + i%8] = a[i];
         4'd5, 4'd6, 4'd7, 4'd8: begin
            sh = (c == 4'd5) ? 8 * int'(b[2:0]) : 16 * (int'(c) - 5);
            for (int i = 0; i < W; i++)
               r[i] = (i + sh < W) ? ((c == 4'd5) ? d[i+sh] : b[i+sh]) : a[i+sh-W];
         end
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic string req_of(input logic [3:0] c);
      case (c)
         4'd0: return "R1";
         4'd1: return "R2";
         4'd2: return "R3";
         4'd3: return "R4";
         4'd4: return "R5";
         4'd5: return "R6";
         4'd6, 4'd7, 4'd8: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // drive at a falling edge, result is registered at the next rising edge,
   // sampled at the falling edge after it
   task automatic run_op(input logic [3:0] c, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic [W-1:0] d, input bit v);
      @(negedge clk);
      op = c; src_a = a; src_b = b; src_d = d; valid_in = v;
      @(negedge clk);
      check(req_of(c), "result", result, ref_model(c, a, b, d));
      check((c > 4'd8) ? "R9" : req_of(c), "illegal", W'(illegal), W'(c > 4'd8));
      check("R10", "valid_out", W'(valid_out), W'(v));
   endtask

   initial begin
      logic [W-1:0] a, b, d, r_dirty, r_clean;
      logic [3:0]   c;
      void'($urandom(32'h5eed_b17e));
      rst = 1'b1; valid_in = 1'b1; op = 4'd2; src_a = '1; src_b = '1; src_d = '1;
      repeat (3) @(negedge clk);
      check("R10", "reset valid_out", W'(valid_out), '0);
      check("R10", "reset result", result, '0);
      check("R10", "reset illegal", W'(illegal), '0);
      rst = 1'b0;

      // corner words for every defined code
      for (int k = 0; k <= 8; k++) begin
         run_op(4'(k), '0, 64'h0123_4567_89ab_cdef, 64'hfedc_ba98_7654_3210, 1'b1);
         run_op(4'(k), '1, 64'h0f0f_0f0f_0f0f_0f0f, 64'h1122_3344_5566_7788, 1'b0);
      end

      // a single set bit walked over every position, R1 to R5
      for (int p = 0; p < W; p++)
         for (int k = 0; k <= 4; k++)
            run_op(4'(k), W'(1) << p, '0, '0, p[0]);

      // every byte offset of the variable align, upper B bits ignored (R6, R7)
      for (int s = 0; s < 8; s++) begin
         a = {$urandom, $urandom}; d = {$urandom, $urandom};
         b = {$urandom, $urandom};
         b[2:0] = 3'(s);
         run_op(4'd5, a, b, d, 1'b1);
         r_dirty = result;
         run_op(4'd5, a, W'(s), d, 1'b1);
         r_clean = result;
         check("R7", "upper B bits changed align", r_dirty, r_clean);
         if (s == 0) check("R6", "zero offset keeps D", r_clean, d);
      end

      // every undefined code, R9
      for (int k = 9; k < 16; k++)
         run_op(4'(k), {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, 1'b1);

      // seeded random mix
      for (int n = 0; n < 2000; n++) begin
         c = 4'($urandom_range(0, 15));
         a = {$urandom, $urandom}; b = {$urandom, $urandom}; d = {$urandom, $urandom};
         if (n % 7 == 0) a = a & {$urandom, $urandom} & {$urandom, $urandom};
         run_op(c, a, b, d, 1'($urandom));
      end

      // synchronous reset mid-stream, R10
      @(negedge clk);
      op = 4'd4; src_a = '1; valid_in = 1'b1; rst = 1'b1;
      @(negedge clk);
      check("R10", "mid reset valid_out", W'(valid_out), '0);
      check("R10", "mid reset result", result, '0);
      rst = 1'b0;

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule